// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block collects three interrupt causes from a graphics engine and presents them to software through a small register bus. Two causes are single-cycle event pulses: one for the end of a binning pass and one for a completed rendered frame. Each pulse latches a pending bit. The third cause is a level that stays high while the binner has run out of memory. Its pending bit is refreshed from that level on every cycle. An acknowledge therefore cannot remove it while the condition lasts.

Software clears pending bits by writing ones to the status address. Software never writes the enable mask directly. Writing ones to one address turns enable bits on, and writing ones to another address turns them off. Both of these addresses read back the same mask. A single interrupt line is high whenever a pending bit is also enabled.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: Writing the status address (byte address 0x0) clears every pending bit whose written data bit is 1. Data bits written as 0 leave their pending bits unchanged.
- R2: Writing the enable-set address (0x4) turns on every enable bit whose data bit is 1. The other enable bits keep their values.
- R3: Writing the enable-clear address (0x8) turns off every enable bit whose data bit is 1. The other enable bits keep their values.
- R4: A read of 0x4 and a read of 0x8 both return the current enable mask in bits 2:0.
- R5: An acknowledged frame-done or flush-done bit stays clear until a new pulse arrives on its event input.
- R6: The out-of-memory pending bit is set on every cycle that its level input is high, including the cycle of an acknowledge. It clears only through an acknowledge made while the level is low.
- R7: If an event pulse and a write-1 acknowledge of the same bit occur in the same cycle, the bit ends up set.
- R8: `irq_out` is a register that is high exactly when the pending bits ANDed with the enable bits give a nonzero result. It changes at the same clock edge as the state it reflects.
- R9: After reset, all pending bits, all enable bits and `irq_out` are zero.
- R10: The bit positions are: frame done at bit 0, flush done at bit 1, out of memory at bit 2. Bits 31:3 always read as zero.
- R11: Writes to any address other than 0x0, 0x4 and 0x8 change nothing. Reads of any such address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register being accessed |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev_frame_done | input | 1 | One-cycle pulse when a frame has finished rendering |
| ev_flush_done | input | 1 | One-cycle pulse when the binner has flushed |
| oom_level | input | 1 | High while the binner has no memory |
| irq_out | output | 1 | Registered interrupt request |

## Verification
Two things can land on one status bit in the same cycle: an engine event that sets it and a software acknowledge that clears it. The bench provokes this in two ways. Directed cases put a pulse and a write-1 to the same bit on the same edge. Random traffic does the same for the held out-of-memory level, acknowledging it while the level is high and again after the level drops. A bench-side model decides that the setting side wins. Every status read-back and every cycle of `irq_out` is compared against that model.

// File: rtl/gic_pkg.sv
package gic_pkg;
    localparam int NSRC    = 3;
    localparam int B_FRAME = 0;
    localparam int B_FLUSH = 1;
    localparam int B_OOM   = 2;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_ESET,
        SEL_ECLR
    } sel_e;

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic            irq;
    } ctl_t;
endpackage

// File: rtl/gic_decode.sv
module gic_decode
    import gic_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] A_STAT = 'h0,
    parameter logic [ADDR_W-1:0] A_ESET = 'h4,
    parameter logic [ADDR_W-1:0] A_ECLR = 'h8
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);
    always_comb begin
        if (addr == A_STAT)      sel = SEL_STAT;
        else if (addr == A_ESET) sel = SEL_ESET;
        else if (addr == A_ECLR) sel = SEL_ECLR;
        else                     sel = SEL_NONE;
    end
endmodule

// File: rtl/gic_pend.sv
module gic_pend #(
    parameter int NSRC = 3,
    parameter logic [NSRC-1:0] LEVEL_MASK = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] cause,
    input  logic [NSRC-1:0] ack,
    output logic [NSRC-1:0] pend_d,
    output logic [NSRC-1:0] pend_q
);
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        if (LEVEL_MASK[i]) begin : g_level
            // Held cause: re-asserted every cycle it is present.
            always_comb pend_d[i] = cause[i] | (pend_q[i] & ~ack[i]);
        end else begin : g_pulse
            // Pulse cause: latched; the new event wins over an ack.
            always_comb pend_d[i] = (pend_q[i] & ~ack[i]) | cause[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl
    import gic_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] A_STAT = 'h0,
    parameter logic [ADDR_W-1:0] A_ESET = 'h4,
    parameter logic [ADDR_W-1:0] A_ECLR = 'h8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_frame_done,
    input  logic              ev_flush_done,
    input  logic              oom_level,
    output logic              irq_out
);
    localparam int PAD_W = DATA_W - NSRC;
    localparam logic [NSRC-1:0] LEVEL_SRCS = NSRC'(1) << B_OOM;

    sel_e            sel;
    logic [NSRC-1:0] wmask;
    logic [NSRC-1:0] ack;
    logic [NSRC-1:0] cause;
    logic [NSRC-1:0] pend_d;
    logic [NSRC-1:0] pend_q;
    ctl_t            st_d;
    ctl_t            st_q;

    gic_decode #(
        .ADDR_W(ADDR_W), .A_STAT(A_STAT), .A_ESET(A_ESET), .A_ECLR(A_ECLR)
    ) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    always_comb begin
        wmask = bus_wdata[NSRC-1:0];
        ack   = (bus_we && sel == SEL_STAT) ? wmask : '0;
        cause = '0;
        cause[B_FRAME] = ev_frame_done;
        cause[B_FLUSH] = ev_flush_done;
        cause[B_OOM]   = oom_level;
    end

    gic_pend #(.NSRC(NSRC), .LEVEL_MASK(LEVEL_SRCS)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .cause (cause),
        .ack   (ack),
        .pend_d(pend_d),
        .pend_q(pend_q)
    );

    always_comb begin
        st_d = st_q;
        if (bus_we && sel == SEL_ESET) st_d.en = st_q.en | wmask;
        if (bus_we && sel == SEL_ECLR) st_d.en = st_q.en & ~wmask;
        st_d.irq = |(pend_d & st_d.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (sel)
            SEL_STAT: bus_rdata = {{PAD_W{1'b0}}, pend_q};
            SEL_ESET,
            SEL_ECLR: bus_rdata = {{PAD_W{1'b0}}, st_q.en};
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_out = st_q.irq;
endmodule

// File: rtl/gic_irq_chk.sv
module gic_irq_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int NSRC   = 3,
    parameter logic [ADDR_W-1:0] A_STAT = 'h0,
    parameter logic [ADDR_W-1:0] A_ESET = 'h4,
    parameter logic [ADDR_W-1:0] A_ECLR = 'h8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              ev_frame_done,
    input logic              ev_flush_done,
    input logic              oom_level,
    input logic              irq_out,
    input logic [NSRC-1:0]   pend,
    input logic [NSRC-1:0]   en
);
    p_w1c_flush_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_STAT && bus_wdata[1] && !ev_flush_done) |=> !pend[1]);

    p_ena_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_ESET && bus_wdata[0]) |=> en[0]);

    p_ena_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_ECLR && bus_wdata[2]) |=> !en[2]);

    p_oom_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oom_level |=> pend[2]);

    p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_frame_done |=> pend[0]);

    p_irq_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|(pend & en)));

    p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NSRC] == '0);

    p_en_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (bus_addr == A_ESET || bus_addr == A_ECLR)) |=> $stable(en));
endmodule

bind gfx_irq_ctrl gic_irq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(gic_pkg::NSRC),
    .A_STAT(A_STAT), .A_ESET(A_ESET), .A_ECLR(A_ECLR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .ev_frame_done(ev_frame_done),
    .ev_flush_done(ev_flush_done),
    .oom_level    (oom_level),
    .irq_out      (irq_out),
    .pend         (pend_q),
    .en           (st_q.en)
);

// File: tb/gfx_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gfx_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ev_frame_done = 1'b0;
    logic        ev_flush_done = 1'b0;
    logic        oom_level = 1'b0;
    logic        irq_out;

    int n_run = 0;
    int n_fail = 0;
    logic [2:0] m_pend = '0;
    logic [2:0] m_en = '0;

    always #5 clk = ~clk;

    gfx_irq_ctrl u_gfx_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_frame_done(ev_frame_done), .ev_flush_done(ev_flush_done),
        .oom_level(oom_level), .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        case (a)
            4'h0:      return {29'b0, m_pend};
            4'h4, 4'h8: return {29'b0, m_en};
            default:   return 32'b0;
        endcase
    endfunction

    function automatic logic [2:0] next_pend(input logic [3:0] a, input logic we,
            input logic [31:0] d, input logic fr, input logic fl, input logic oom);
        logic [2:0] ack;
        ack = (we && a == 4'h0) ? d[2:0] : 3'b0;
        return (m_pend & ~ack) | {oom, fl, fr};
    endfunction

    function automatic logic [2:0] next_en(input logic [3:0] a, input logic we,
            input logic [31:0] d);
        if (we && a == 4'h4) return m_en | d[2:0];
        if (we && a == 4'h8) return m_en & ~d[2:0];
        return m_en;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
            input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge; check read data before the
    // rising edge, then update the model and check irq_out after it.
    task automatic step(input logic [3:0] a, input logic we, input logic [31:0] d,
            input logic fr, input logic fl, input logic oom, input string req);
        logic [2:0] np;
        logic [2:0] ne;
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = d;
        ev_frame_done = fr; ev_flush_done = fl; oom_level = oom;
        #1;
        if (!we) chk(bus_rdata == exp_read(a), req, bus_rdata, exp_read(a));
        np = next_pend(a, we, d, fr, fl, oom);
        ne = next_en(a, we, d);
        @(posedge clk);
        m_pend = np; m_en = ne;
        #1;
        chk(irq_out == |(m_pend & m_en), "R8", {31'b0, irq_out}, {31'b0, |(m_pend & m_en)});
    endtask

    task automatic rd(input logic [3:0] a, input logic oom, input string req);
        step(a, 1'b0, 32'b0, 1'b0, 1'b0, oom, req);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic oom);
        step(a, 1'b1, d, 1'b0, 1'b0, oom, "R11");
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #22 rst_n = 1'b1;
        // R9: reset state
        chk(irq_out == 1'b0, "R9", {31'b0, irq_out}, 32'b0);
        rd(4'h0, 1'b0, "R9");
        rd(4'h4, 1'b0, "R9");
        // R2, R4: enable set, read at both addresses
        wr(4'h4, 32'h0000_0005, 1'b0);
        rd(4'h4, 1'b0, "R2");
        rd(4'h8, 1'b0, "R4");
        wr(4'h4, 32'hFFFF_FFF8, 1'b0);
        rd(4'h8, 1'b0, "R2");
        // R3: enable clear with zeros ignored
        wr(4'h8, 32'h0000_0004, 1'b0);
        rd(4'h4, 1'b0, "R3");
        wr(4'h4, 32'h0000_0007, 1'b0);
        // R10: bit positions
        step(4'h0, 1'b0, 32'b0, 1'b1, 1'b0, 1'b0, "R10");
        rd(4'h0, 1'b0, "R10");
        step(4'h0, 1'b0, 32'b0, 1'b0, 1'b1, 1'b0, "R10");
        rd(4'h0, 1'b0, "R10");
        // R1: ack only bit 0, bit 1 stays
        wr(4'h0, 32'h0000_0001, 1'b0);
        rd(4'h0, 1'b0, "R1");
        // R5: stays clear after ack with no event
        wr(4'h0, 32'h0000_0002, 1'b0);
        rd(4'h0, 1'b0, "R5");
        rd(4'h0, 1'b0, "R5");
        // R7: event and ack of the same bit together
        step(4'h0, 1'b1, 32'h0000_0001, 1'b1, 1'b0, 1'b0, "R7");
        rd(4'h0, 1'b0, "R7");
        wr(4'h0, 32'h0000_0001, 1'b0);
        // R6: out-of-memory held through an ack
        rd(4'h0, 1'b1, "R6");
        wr(4'h0, 32'h0000_0004, 1'b1);
        rd(4'h0, 1'b1, "R6");
        rd(4'h0, 1'b0, "R6");
        wr(4'h0, 32'h0000_0004, 1'b0);
        rd(4'h0, 1'b0, "R6");
        // R11: stray address write and read
        step(4'h0, 1'b0, 32'b0, 1'b1, 1'b1, 1'b0, "R11");
        wr(4'hC, 32'hFFFF_FFFF, 1'b0);
        wr(4'h2, 32'hFFFF_FFFF, 1'b0);
        rd(4'h0, 1'b0, "R11");
        rd(4'h4, 1'b0, "R11");
        rd(4'hC, 1'b0, "R11");
        // Constrained random traffic checked against the model
        for (int i = 0; i < 2000; i++) begin
            logic [3:0] a;
            logic [1:0] pick;
            pick = 2'($urandom_range(0, 3));
            a = (pick == 2'd3) ? 4'($urandom) : {pick, 2'b00};
            step(a, 1'($urandom_range(0, 2) == 0), $urandom,
                 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
                 1'($urandom_range(0, 4) == 0), "R1");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule